// File: doc/BRIEF.md
# Event Counter Group

This block holds a bank of event counters, each `CTR_W` bits wide, behind a 32-bit register port. Each counter has an event-type register and a stream filter register. These two are only storage; the logic that sources events reads them. Three 64-bit bit masks are each reached through a write-one-to-set address and a write-one-to-clear address: counter enable, interrupt enable and overflow status. A counter advances on its `evt_inc` pulse only while the global count enable and its own enable bit are both on. When a counter wraps from all ones to zero, its overflow bit is set.

The interrupt output is the OR of the overflow bits whose interrupt enable is set, gated by a global interrupt enable. A read-only configuration word reports the counter count, the counter width, the global-filter flag and the message-signalled-interrupt flag. A 128-bit supported-event bitmap is also readable. Software can load any counter, for example to half its range, so that the overflow interrupt fires after a chosen number of events.

Top module: `evt_counter_group`

## Requirements
- R1: After synchronous reset, every counter, every mask, the global count enable and the global interrupt enable are zero, `irq` is low and `reg_rdata` is zero.
- R2: The word at 0xE00 reads {8'b0, global-filter flag (bit 23), 1'b0, MSI flag (bit 21), relocation flag (bit 20, always 0), 6'b0, CTR_W-1 (bits 13:8), 2'b0, NUM_CTR-1 (bits 5:0)}; with the defaults this is 0x00202703.
- R3: Counter n increments by one on a cycle where `evt_inc[n]` is high only if bit 0 of 0xE04 (global count enable) is set and bit n of the counter-enable mask is set; otherwise it holds.
- R4: When CTR_W > 32, counter n's low word is at 0x000+8n and its upper CTR_W-32 bits are at 0x004+8n (zero-extended on read). When CTR_W ≤ 32 the stride is 4. Written values read back.
- R5: The counter-enable mask is set at 0xC00/0xC04 and cleared at 0xC20/0xC24 (low/high 32 bits); the interrupt-enable mask is set at 0xC40/0xC44 and cleared at 0xC60/0xC64. Only bits written as one change, and either address of a pair reads the current mask.
- R6: When an enabled counter wraps from all ones to zero, it reads zero and its overflow status bit becomes one.
- R7: Overflow status is cleared at 0xC80/0xC84 and set at 0xCC0/0xCC4, write-one-only, and either address reads the current status.
- R8: `irq` is high exactly when bit 0 of 0xE50 is set and some overflow bit has its interrupt-enable bit set. It follows register updates in the same cycle they take effect.
- R9: Counter, event-type and filter addresses for an index ≥ NUM_CTR read zero and ignore writes; mask bits at or above NUM_CTR read zero.
- R10: Event-type register n at 0x400+4n and filter register n at 0xA00+4n store and read back all 32 bits.
- R11: The supported-event bitmap reads as four words at 0xE20, 0xE24, 0xE28 and 0xE2C, lowest bits first.
- R12: A register write to a counter in the same cycle as its increment takes the written value. A hardware overflow set in the same cycle as a clear write leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| evt_inc | input | NUM_CTR | Per-counter event pulse |
| irq | output | 1 | Overflow interrupt |

## Verification
A register write takes effect at the clock edge that samples the strobe. Read data is registered and is valid after the edge that samples `reg_rd`. A counter moves at the edge that samples its `evt_inc` pulse. `irq` is combinational from the registers, so it changes in the same cycle as the register update behind it. The bench drives every input on the falling edge and samples outputs on the next falling edge, one full edge after the register that produces them.

// File: rtl/evcg_pkg.sv
package evcg_pkg;

    typedef enum logic [3:0] {
        RG_NONE, RG_CNT, RG_EVT, RG_FLT,
        RG_EN_S, RG_EN_C, RG_IE_S, RG_IE_C,
        RG_OV_C, RG_OV_S, RG_CFG, RG_CTL,
        RG_IRQC, RG_SUPP
    } reg_region_e;

    typedef struct packed {
        reg_region_e region;
        logic [7:0]  idx;
        logic        upper;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [11:0] a, input logic wide);
        reg_sel_t s;
        s.region = RG_NONE;
        s.idx    = '0;
        s.upper  = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (a[11:10] == 2'b00) begin
                s.region = RG_CNT;
                s.idx    = wide ? {1'b0, a[9:3]} : a[9:2];
                s.upper  = wide & a[2];
            end else if (a[11:8] == 4'h4) begin
                s.region = RG_EVT;
                s.idx    = {2'b00, a[7:2]};
            end else if (a[11:8] == 4'hA) begin
                s.region = RG_FLT;
                s.idx    = {2'b00, a[7:2]};
            end else if (a == 12'hE00) begin
                s.region = RG_CFG;
            end else if (a == 12'hE04) begin
                s.region = RG_CTL;
            end else if (a == 12'hE50) begin
                s.region = RG_IRQC;
            end else if (a[11:4] == 8'hE2) begin
                s.region = RG_SUPP;
                s.idx    = {6'b0, a[3:2]};
            end else begin
                s.upper = a[2];
                case ({a[11:3], 3'b000})
                    12'hC00: s.region = RG_EN_S;
                    12'hC20: s.region = RG_EN_C;
                    12'hC40: s.region = RG_IE_S;
                    12'hC60: s.region = RG_IE_C;
                    12'hC80: s.region = RG_OV_C;
                    12'hCC0: s.region = RG_OV_S;
                    default: s.region = RG_NONE;
                endcase
            end
        end
        return s;
    endfunction

    function automatic logic [31:0] build_cfg(input int nctr, input int width,
                                              input logic msi, input logic gfilt);
        logic [31:0] w;
        w        = '0;
        w[5:0]   = 6'(nctr - 1);
        w[13:8]  = 6'(width - 1);
        w[20]    = 1'b0;
        w[21]    = msi;
        w[23]    = gfilt;
        return w;
    endfunction

endpackage

// File: rtl/evcg_counter.sv
module evcg_counter #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         count_en,
    input  logic         inc,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [31:0]  wdata,
    output logic [W-1:0] value,
    output logic         wrap
);
    localparam int HW = (W > 32) ? W - 32 : 1;

    logic [W-1:0] wr_val;
    logic         wr_any;
    logic         step;

    generate
        if (W > 32) begin : g_wide
            always_comb begin
                wr_val = value;
                if (wr_lo) wr_val[31:0] = wdata;
                if (wr_hi) wr_val[W-1:32] = wdata[HW-1:0];
            end
        end else begin : g_narrow
            always_comb wr_val = wdata[W-1:0];
        end
    endgenerate

    always_comb begin
        wr_any = wr_lo | wr_hi;
        step   = count_en & inc & ~wr_any;
        wrap   = step & (&value);
    end

    always_ff @(posedge clk) begin
        if (rst)         value <= '0;
        else if (wr_any) value <= wr_val;
        else if (step)   value <= value + 1'b1;
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo && !wr_hi && !(count_en && inc)) |=> $stable(value));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo && !wr_hi && count_en && inc && !(&value)) |=> (value == $past(value) + 1'b1));

    // R6
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (value == '0));

endmodule

// File: rtl/evcg_mask.sv
module evcg_mask #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_lo,
    input  logic         set_hi,
    input  logic         clr_lo,
    input  logic         clr_hi,
    input  logic [31:0]  wdata,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] bits
);
    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;

    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            if (b < 32) begin : g_lo
                assign set_v[b] = set_lo & wdata[b];
                assign clr_v[b] = clr_lo & wdata[b];
            end else begin : g_hi
                assign set_v[b] = set_hi & wdata[b-32];
                assign clr_v[b] = clr_hi & wdata[b-32];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) bits <= '0;
        else     bits <= (bits & ~clr_v) | set_v | hw_set;
    end

    // R5
    mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_lo || clr_hi || set_lo || set_hi) && wdata == '0 && hw_set == '0) |=> $stable(bits));

    // R12
    hw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((bits & $past(hw_set)) == $past(hw_set)));

endmodule

// File: rtl/evt_counter_group.sv
module evt_counter_group
    import evcg_pkg::*;
#(
    parameter int           NUM_CTR     = 4,
    parameter int           CTR_W       = 40,
    parameter bit           HAS_MSI     = 1'b1,
    parameter bit           GLOBAL_FILT = 1'b0,
    parameter logic [127:0] SUPP_EVT    = 128'hFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [11:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_CTR-1:0] evt_inc,
    output logic               irq
);
    localparam bit          WIDE    = (CTR_W > 32);
    localparam int          IW      = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
    localparam logic [31:0] CFG_VAL = build_cfg(NUM_CTR, CTR_W, HAS_MSI, GLOBAL_FILT);

    reg_sel_t         sel;
    logic             idx_ok;
    logic [IW-1:0]    idx_s;
    logic             glb_en_q, irq_en_q;
    logic [CTR_W-1:0] cnt_val [NUM_CTR];
    logic [31:0]      evt_q   [NUM_CTR];
    logic [31:0]      flt_q   [NUM_CTR];
    logic [NUM_CTR-1:0] wrap_v, en_m, ie_m, ov_m;
    logic [31:0]      rd_nxt;

    always_comb begin
        sel    = decode_addr(reg_addr, WIDE);
        idx_ok = (sel.idx < 8'(NUM_CTR));
        idx_s  = sel.idx[IW-1:0];
    end

    function automatic logic wr_hit(input reg_region_e r, input logic hi);
        return reg_wr && sel.region == r && sel.upper == hi;
    endfunction

    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
            logic hit;
            assign hit = reg_wr && sel.region == RG_CNT && sel.idx == 8'(i);

            evcg_counter #(.W(CTR_W)) u_cnt (
                .clk      (clk),
                .rst      (rst),
                .count_en (glb_en_q & en_m[i]),
                .inc      (evt_inc[i]),
                .wr_lo    (hit & ~sel.upper),
                .wr_hi    (hit & sel.upper),
                .wdata    (reg_wdata),
                .value    (cnt_val[i]),
                .wrap     (wrap_v[i])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    evt_q[i] <= '0;
                    flt_q[i] <= '0;
                end else if (reg_wr && sel.idx == 8'(i)) begin
                    if (sel.region == RG_EVT) evt_q[i] <= reg_wdata;
                    if (sel.region == RG_FLT) flt_q[i] <= reg_wdata;
                end
            end
        end
    endgenerate

    evcg_mask #(.N(NUM_CTR)) u_en (
        .clk(clk), .rst(rst),
        .set_lo(wr_hit(RG_EN_S, 1'b0)), .set_hi(wr_hit(RG_EN_S, 1'b1)),
        .clr_lo(wr_hit(RG_EN_C, 1'b0)), .clr_hi(wr_hit(RG_EN_C, 1'b1)),
        .wdata(reg_wdata), .hw_set('0), .bits(en_m)
    );

    evcg_mask #(.N(NUM_CTR)) u_ie (
        .clk(clk), .rst(rst),
        .set_lo(wr_hit(RG_IE_S, 1'b0)), .set_hi(wr_hit(RG_IE_S, 1'b1)),
        .clr_lo(wr_hit(RG_IE_C, 1'b0)), .clr_hi(wr_hit(RG_IE_C, 1'b1)),
        .wdata(reg_wdata), .hw_set('0), .bits(ie_m)
    );

    evcg_mask #(.N(NUM_CTR)) u_ov (
        .clk(clk), .rst(rst),
        .set_lo(wr_hit(RG_OV_S, 1'b0)), .set_hi(wr_hit(RG_OV_S, 1'b1)),
        .clr_lo(wr_hit(RG_OV_C, 1'b0)), .clr_hi(wr_hit(RG_OV_C, 1'b1)),
        .wdata(reg_wdata), .hw_set(wrap_v), .bits(ov_m)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en_q <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (reg_wr) begin
            if (sel.region == RG_CTL)  glb_en_q <= reg_wdata[0];
            if (sel.region == RG_IRQC) irq_en_q <= reg_wdata[0];
        end
    end

    assign irq = irq_en_q & |(ov_m & ie_m);

    function automatic logic [31:0] half64(input logic [63:0] v, input logic hi);
        return hi ? v[63:32] : v[31:0];
    endfunction

    always_comb begin
        rd_nxt = '0;
        case (sel.region)
            RG_CNT:  if (idx_ok) rd_nxt = half64(64'(cnt_val[idx_s]), sel.upper);
            RG_EVT:  if (idx_ok) rd_nxt = evt_q[idx_s];
            RG_FLT:  if (idx_ok) rd_nxt = flt_q[idx_s];
            RG_EN_S, RG_EN_C: rd_nxt = half64(64'(en_m), sel.upper);
            RG_IE_S, RG_IE_C: rd_nxt = half64(64'(ie_m), sel.upper);
            RG_OV_S, RG_OV_C: rd_nxt = half64(64'(ov_m), sel.upper);
            RG_CFG:  rd_nxt = CFG_VAL;
            RG_CTL:  rd_nxt = {31'b0, glb_en_q};
            RG_IRQC: rd_nxt = {31'b0, irq_en_q};
            RG_SUPP: rd_nxt = SUPP_EVT[32*sel.idx[1:0] +: 32];
            default: rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_nxt;
    end

    // R9
    unimpl_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && (sel.region == RG_CNT || sel.region == RG_EVT || sel.region == RG_FLT)
         && sel.idx >= 8'(NUM_CTR)) |=> (reg_rdata == '0));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel.region == RG_IRQC && !reg_wdata[0]) |=> !irq);

    // R3
    glb_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!glb_en_q && !reg_wr) |=> $stable(cnt_val[0]));

endmodule

// File: tb/evt_counter_group_test.sv
module evt_counter_group_test;
    localparam int CLK_P = 10;
    localparam int NC    = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_wr, reg_rd;
    logic [11:0]   reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [NC-1:0] evt_inc;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    evt_counter_group uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_inc(evt_inc), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse(input logic [NC-1:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_inc = m;
            @(negedge clk);
            evt_inc = '0;
        end
    endtask

    task automatic t_reset;
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rchk("R1 ctr0", 12'h000, 32'h0);
        rchk("R1 en mask", 12'hC00, 32'h0);
        rchk("R1 ovf", 12'hC80, 32'h0);
        rchk("R1 ctl", 12'hE04, 32'h0);
    endtask

    task automatic t_config;
        rchk("R2 cfg", 12'hE00, 32'h0020_2703);
        rchk("R11 supp0", 12'hE20, 32'h0000_00FF);
        rchk("R11 supp1", 12'hE24, 32'h0);
        rchk("R11 supp3", 12'hE2C, 32'h0);
    endtask

    task automatic t_counter_rw;
        wr(12'h008, 32'h1234_5678);
        wr(12'h00C, 32'hFFFF_FFAB);
        rchk("R4 ctr1 lo", 12'h008, 32'h1234_5678);
        rchk("R4 ctr1 hi", 12'h00C, 32'h0000_00AB);
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'h01C, 32'h0000_007F);
        rchk("R4 ctr3 half lo", 12'h018, 32'hFFFF_FFFF);
        rchk("R4 ctr3 half hi", 12'h01C, 32'h0000_007F);
    endtask

    task automatic t_evt_flt;
        wr(12'h404, 32'h2000_0001);
        wr(12'hA04, 32'h0000_0042);
        rchk("R10 evt1", 12'h404, 32'h2000_0001);
        rchk("R10 flt1", 12'hA04, 32'h0000_0042);
        rchk("R10 evt0 untouched", 12'h400, 32'h0);
    endtask

    task automatic t_masks;
        wr(12'hC00, 32'h5);
        rchk("R5 en set", 12'hC00, 32'h5);
        rchk("R5 en via clr", 12'hC20, 32'h5);
        wr(12'hC00, 32'h0);
        rchk("R5 zero set", 12'hC00, 32'h5);
        wr(12'hC20, 32'h1);
        rchk("R5 clr bit0", 12'hC00, 32'h4);
        wr(12'hC00, 32'hFFFF_FFFF);
        rchk("R9 mask width", 12'hC00, 32'hF);
        rchk("R9 mask hi", 12'hC04, 32'h0);
        wr(12'hC20, 32'hFFFF_FFFF);
        wr(12'hC40, 32'h2);
        rchk("R5 ie set", 12'hC60, 32'h2);
        wr(12'hC60, 32'h2);
        rchk("R5 ie clr", 12'hC40, 32'h0);
    endtask

    task automatic t_count;
        wr(12'h000, 32'h0);
        wr(12'h004, 32'h0);
        wr(12'h010, 32'h0);
        wr(12'hC00, 32'h1);
        pulse(4'b0101, 3);
        rchk("R3 glb off", 12'h000, 32'h0);
        wr(12'hE04, 32'h1);
        pulse(4'b0101, 3);
        rchk("R3 counting", 12'h000, 32'h3);
        rchk("R3 own enable off", 12'h010, 32'h0);
        wr(12'h000, 32'hFFFF_FFFF);
        pulse(4'b0001, 1);
        rchk("R3 carry lo", 12'h000, 32'h0);
        rchk("R3 carry hi", 12'h004, 32'h1);
    endtask

    task automatic t_wrap;
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h004, 32'h0000_00FF);
        wr(12'hC40, 32'h1);
        wr(12'hE50, 32'h1);
        chk("R8 no ovf no irq", {31'b0, irq}, 32'h0);
        pulse(4'b0001, 1);
        chk("R8 irq on wrap", {31'b0, irq}, 32'h1);
        rchk("R6 wrap lo", 12'h000, 32'h0);
        rchk("R6 wrap hi", 12'h004, 32'h0);
        rchk("R6 ovf via clr", 12'hC80, 32'h1);
        rchk("R7 ovf via set", 12'hCC0, 32'h1);
        wr(12'hE50, 32'h0);
        chk("R8 global gate", {31'b0, irq}, 32'h0);
        wr(12'hE50, 32'h1);
        chk("R8 regate", {31'b0, irq}, 32'h1);
        wr(12'hC80, 32'h1);
        chk("R7 clear drops irq", {31'b0, irq}, 32'h0);
        rchk("R7 cleared", 12'hC80, 32'h0);
        wr(12'hCC0, 32'h2);
        rchk("R7 sw set", 12'hC80, 32'h2);
        chk("R8 masked source", {31'b0, irq}, 32'h0);
        wr(12'hC40, 32'h2);
        chk("R8 ie on", {31'b0, irq}, 32'h1);
        wr(12'hC80, 32'h3);
        chk("R8 all clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_unimpl;
        wr(12'h028, 32'hDEAD_BEEF);
        rchk("R9 ctr5", 12'h028, 32'h0);
        wr(12'h414, 32'h1);
        rchk("R9 evt5", 12'h414, 32'h0);
        rchk("R9 ctr0 intact", 12'h000, 32'h0);
    endtask

    task automatic t_collide;
        wr(12'h000, 32'd10);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h000; reg_wdata = 32'd100; evt_inc = 4'b0001;
        @(negedge clk);
        reg_wr = 1'b0; evt_inc = '0;
        rchk("R12 write wins", 12'h000, 32'd100);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h004, 32'h0000_00FF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'hC80; reg_wdata = 32'h1; evt_inc = 4'b0001;
        @(negedge clk);
        reg_wr = 1'b0; evt_inc = '0;
        rchk("R12 hw set wins", 12'hC80, 32'h1);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0; evt_inc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_config;
        t_counter_rw;
        t_evt_flt;
        t_masks;
        t_count;
        t_wrap;
        t_unimpl;
        t_collide;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule